// File: doc/BRIEF.md
# Multicycle 16-bit Register-File Processor Core

This block is a small multicycle processor core for a word-addressed machine. Each instruction is one 16-bit word, and there are eight general registers. Every instruction passes through fetch, decode and address evaluation. Where the instruction needs them, it then goes on to operand fetch, execution and result store. Each state that touches memory makes exactly one access. The core talks to a synchronous single-port memory: the data for a read appears on the cycle after the address.

The core runs twelve instructions:

- register arithmetic and logic: add, bitwise and, complement;
- loads in three addressing styles: PC-relative, register base plus offset, and indirect through a pointer word;
- stores in the same three styles;
- effective-address load;
- conditional branch on the condition codes;
- register jump.

Any other opcode halts the core. The halt output then stays high and the core makes no further memory writes until reset.

Top module: `mc16_core`

## Requirements
- R1: While reset is held low, memAddr shows x3000, memWe is low and halted is low. After reset, all eight registers hold zero and the condition codes {N,Z,P} are 000, so a branch with mask 111 as the first instruction is not taken.
- R2: Every instruction begins with a fetch cycle that drives memAddr with PC. PC then advances by one before decode. Add, and, complement, effective-address load, branch and jump take 3 cycles each.
- R3: Opcode is IR[15:12]. Add is 0001 and and is 0101, with DR=IR[11:9] and SR1=IR[8:6]. IR[5]=0 takes the second source from register IR[2:0]. IR[5]=1 takes IR[4:0] sign-extended to 16 bits. A source register may also be the destination.
- R4: Complement is 1001 with DR=IR[11:9], SR=IR[8:6] and IR[5:0]=111111. It writes the bitwise inverse of SR.
- R5: Every register write sets exactly one of the condition codes from the written value: N if bit 15 is set, Z if the value is zero, P otherwise. This holds for operate, load and effective-address instructions.
- R6: PC-relative addresses are the incremented PC plus IR[8:0] sign-extended. Base-plus-offset addresses are register IR[8:6] plus IR[5:0] sign-extended. The load opcodes are 0010 (PC-relative) and 0110 (base plus offset); each takes 5 cycles and reads its operand in cycle 4. The effective-address load (1110) writes the PC-relative address into DR.
- R7: The store opcodes are 0011 (PC-relative) and 0111 (base plus offset). Each takes 4 cycles and writes register IR[11:9] to the computed address in cycle 4. That is the only cycle with memWe high.
- R8: Indirect load (1010) reads the pointer word in cycle 4 and the operand at the pointer in cycle 6, for 7 cycles in total. Indirect store (1011) reads the pointer in cycle 4 and writes register IR[11:9] at the pointer in cycle 6, for 6 cycles in total.
- R9: Branch (0000) takes its mask from IR[11:9] as {n,z,p}. It is taken when any mask bit matches a set condition code, and the target is the incremented PC plus IR[8:0] sign-extended.
- R10: Jump (1100) loads PC with register IR[8:6].
- R11: Any other opcode (0100, 1000, 1101, 1111) raises halted from the cycle after its third cycle. halted stays high, and memWe stays low from then on.
- R12: Read data is sampled on the cycle after the address is driven. Write data is valid in the cycle that memWe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| memAddr | output | 16 | Word address of the memory access |
| memWdata | output | 16 | Data to be written |
| memWe | output | 1 | Write enable for the current cycle |
| memRdata | input | 16 | Read data for the address of the previous cycle |
| halted | output | 1 | High once an unsupported opcode has been decoded |

## Verification
The assertions take for granted that memRdata returns the word at the previous cycle's address, one cycle later, and that the memory is always ready. The bench memory keeps to this with a one-cycle registered read that never stalls.

The assertions also assume that the register-write strobe is only paired with a well-defined write-back value. The test program is built only from well-formed encodings of the twelve instructions, so this holds. A single unsupported opcode at the very end exercises the halt path.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

  localparam logic [3:0] OP_BR  = 4'b0000;
  localparam logic [3:0] OP_ADD = 4'b0001;
  localparam logic [3:0] OP_LD  = 4'b0010;
  localparam logic [3:0] OP_ST  = 4'b0011;
  localparam logic [3:0] OP_AND = 4'b0101;
  localparam logic [3:0] OP_LDR = 4'b0110;
  localparam logic [3:0] OP_STR = 4'b0111;
  localparam logic [3:0] OP_NOT = 4'b1001;
  localparam logic [3:0] OP_LDI = 4'b1010;
  localparam logic [3:0] OP_STI = 4'b1011;
  localparam logic [3:0] OP_JMP = 4'b1100;
  localparam logic [3:0] OP_LEA = 4'b1110;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_EVAL, S_PTR, S_PTRLAT,
    S_OPRD, S_WBACK, S_STORE, S_HALT
  } stateT;

  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_EA} wbSelT;

  typedef struct packed {
    logic  pcInc;
    logic  brEval;
    logic  jmp;
    logic  irLoad;
    logic  marLoad;
    logic  marBase;
    logic  marFromMem;
    logic  regWe;
    wbSelT wbSel;
    logic  addrMar;
    logic  memWe;
  } strobeT;

endpackage

// File: rtl/mc16_dpath.sv
module mc16_dpath
  import mc16_pkg::*;
#(
  parameter int              DATA_W   = 16,
  parameter int              NUM_REGS = 8,
  parameter logic [DATA_W-1:0] RESET_PC = 16'h3000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [3:0]        opcode
);

  localparam int REG_AW = $clog2(NUM_REGS);

  logic [DATA_W-1:0] pc, ir, mar;
  logic [2:0]        cc;  // {N,Z,P}
  logic [DATA_W-1:0] rf [NUM_REGS];

  logic [REG_AW-1:0] drIdx, sr1Idx, sr2Idx;
  logic [DATA_W-1:0] srcA, srcB, srcSt, opB;
  logic [DATA_W-1:0] sext5, sext6, sext9;
  logic [DATA_W-1:0] pcRel, ea, aluOut, wbData;
  logic [2:0]        ccNext;
  logic              brTaken;

  assign opcode = ir[15:12];
  assign drIdx  = ir[11:9];
  assign sr1Idx = ir[8:6];
  assign sr2Idx = ir[2:0];

  assign srcA  = rf[sr1Idx];
  assign srcB  = rf[sr2Idx];
  assign srcSt = rf[drIdx];

  assign sext5 = {{(DATA_W-5){ir[4]}}, ir[4:0]};
  assign sext6 = {{(DATA_W-6){ir[5]}}, ir[5:0]};
  assign sext9 = {{(DATA_W-9){ir[8]}}, ir[8:0]};

  assign opB   = ir[5] ? sext5 : srcB;
  assign pcRel = pc + sext9;
  assign ea    = strobes.marBase ? (srcA + sext6) : pcRel;

  always_comb begin
    case (opcode)
      OP_ADD:  aluOut = srcA + opB;
      OP_AND:  aluOut = srcA & opB;
      default: aluOut = ~srcA;
    endcase
  end

  always_comb begin
    case (strobes.wbSel)
      WB_MEM:  wbData = memRdata;
      WB_EA:   wbData = pcRel;
      default: wbData = aluOut;
    endcase
  end

  assign ccNext  = {wbData[DATA_W-1], wbData == '0,
                    !wbData[DATA_W-1] && (wbData != '0)};
  assign brTaken = |(ir[11:9] & cc);

  assign memAddr  = strobes.addrMar ? mar : pc;
  assign memWdata = srcSt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc  <= RESET_PC;
      ir  <= '0;
      mar <= '0;
      cc  <= '0;
      for (int i = 0; i < NUM_REGS; i++) rf[i] <= '0;
    end else begin
      if (strobes.pcInc)                  pc <= pc + DATA_W'(1);
      else if (strobes.brEval && brTaken) pc <= pcRel;
      else if (strobes.jmp)               pc <= srcA;

      if (strobes.irLoad)     ir  <= memRdata;
      if (strobes.marLoad)    mar <= ea;
      if (strobes.marFromMem) mar <= memRdata;

      if (strobes.regWe) begin
        rf[drIdx] <= wbData;
        cc        <= ccNext;
      end
    end
  end

  // R2: PC steps by one across a fetch
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pcInc |=> pc == $past(pc) + DATA_W'(1));

  // R12: instruction word captured from the read returned after fetch
  a_r12_ir_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobes.irLoad |=> ir == $past(memRdata));

  // R5: a register write leaves exactly one condition code set
  a_r5_cc_single: assert property (@(posedge clk) disable iff (!rstN)
    strobes.regWe |=> $countones(cc) == 1);

  // R8: pointer word becomes the operand address
  a_r8_ptr_latch: assert property (@(posedge clk) disable iff (!rstN)
    strobes.marFromMem |=> mar == $past(memRdata));

endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
  import mc16_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] opcode,
  output strobeT     strobes,
  output logic       halted
);

  stateT state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_FETCH;
    else       state <= nextState;
  end

  always_comb begin
    strobes   = '0;
    nextState = state;
    case (state)
      S_FETCH: begin
        strobes.pcInc = 1'b1;
        nextState     = S_DECODE;
      end
      S_DECODE: begin
        strobes.irLoad = 1'b1;
        nextState      = S_EVAL;
      end
      S_EVAL: begin
        nextState = S_FETCH;
        case (opcode)
          OP_ADD, OP_AND, OP_NOT: begin
            strobes.regWe = 1'b1;
            strobes.wbSel = WB_ALU;
          end
          OP_LEA: begin
            strobes.regWe = 1'b1;
            strobes.wbSel = WB_EA;
          end
          OP_BR:  strobes.brEval = 1'b1;
          OP_JMP: strobes.jmp    = 1'b1;
          OP_LD: begin
            strobes.marLoad = 1'b1;
            nextState       = S_OPRD;
          end
          OP_LDR: begin
            strobes.marLoad = 1'b1;
            strobes.marBase = 1'b1;
            nextState       = S_OPRD;
          end
          OP_LDI, OP_STI: begin
            strobes.marLoad = 1'b1;
            nextState       = S_PTR;
          end
          OP_ST: begin
            strobes.marLoad = 1'b1;
            nextState       = S_STORE;
          end
          OP_STR: begin
            strobes.marLoad = 1'b1;
            strobes.marBase = 1'b1;
            nextState       = S_STORE;
          end
          default: nextState = S_HALT;
        endcase
      end
      S_PTR: begin
        strobes.addrMar = 1'b1;
        nextState       = S_PTRLAT;
      end
      S_PTRLAT: begin
        strobes.marFromMem = 1'b1;
        nextState          = (opcode == OP_LDI) ? S_OPRD : S_STORE;
      end
      S_OPRD: begin
        strobes.addrMar = 1'b1;
        nextState       = S_WBACK;
      end
      S_WBACK: begin
        strobes.regWe = 1'b1;
        strobes.wbSel = WB_MEM;
        nextState     = S_FETCH;
      end
      S_STORE: begin
        strobes.addrMar = 1'b1;
        strobes.memWe   = 1'b1;
        nextState       = S_FETCH;
      end
      default: nextState = S_HALT;
    endcase
  end

  assign halted = (state == S_HALT);

  // R11: once halted, the core stays halted
  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // R2: a fetch is always followed by decode
  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FETCH) |=> (state == S_DECODE));

endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter int                NUM_REGS = 8,
  parameter logic [DATA_W-1:0] RESET_PC = 16'h3000
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              halted
);

  strobeT     strobes;
  logic [3:0] opcode;

  mc16_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opcode  (opcode),
    .strobes (strobes),
    .halted  (halted)
  );

  mc16_dpath #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .RESET_PC (RESET_PC)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .opcode   (opcode)
  );

  assign memWe = strobes.memWe;

  // R11: no memory write while halted
  a_r11_no_write_halted: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !memWe);

endmodule

// File: tb/test_mc16_core.sv
`timescale 1ns/1ps
module test_mc16_core;

  logic        clk  = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] memAddr, memWdata, memRdata;
  logic        memWe, halted;

  always #4 clk = ~clk;  // 125 MHz

  mc16_core i_mc16_core (
    .clk      (clk),
    .rstN     (rstN),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .memRdata (memRdata),
    .halted   (halted)
  );

  // Bench memory: 4K words, addresses alias on bits [11:0]
  logic [15:0] mem  [4096];
  logic [15:0] mmem [4096];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4096; i++) mem[i] <= mmem[i];
    end else if (memWe) begin
      mem[memAddr[11:0]] <= memWdata;
    end
    memRdata <= mem[memAddr[11:0]];
  end

  // Reference model state
  logic [15:0] mregs [8];
  logic [15:0] mpc;
  logic [2:0]  mcc;
  bit          mhalted;

  typedef struct packed {
    logic        chk;
    logic        we;
    logic        halt;
    logic [15:0] addr;
    logic [15:0] wdata;
  } itemT;

  itemT  q[$];
  string tq[$];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(bit c, bit w, logic [15:0] a, logic [15:0] d, bit h, string t);
    itemT it;
    it.chk = c; it.we = w; it.halt = h; it.addr = a; it.wdata = d;
    q.push_back(it);
    tq.push_back(t);
  endtask

  task automatic wr(logic [2:0] dr, logic [15:0] v);
    mregs[dr] = v;
    mcc = v[15] ? 3'b100 : (v == 16'h0 ? 3'b010 : 3'b001);
  endtask

  task automatic genStep();
    logic [15:0] ins, s5, s6, s9, ea, ptr, v;
    logic [2:0]  dr, b;
    if (mhalted) begin
      push(0, 0, 16'h0, 16'h0, 1, "R11");
      return;
    end
    ins = mmem[mpc[11:0]];
    push(1, 0, mpc, 16'h0, 0, "R2,R12");
    mpc = mpc + 16'h1;
    push(0, 0, 16'h0, 16'h0, 0, "R2");
    dr = ins[11:9];
    b  = ins[8:6];
    s5 = {{11{ins[4]}}, ins[4:0]};
    s6 = {{10{ins[5]}}, ins[5:0]};
    s9 = {{7{ins[8]}}, ins[8:0]};
    case (ins[15:12])
      4'b0001: begin
        push(0, 0, 0, 0, 0, "R3");
        v = mregs[b] + (ins[5] ? s5 : mregs[ins[2:0]]);
        wr(dr, v);
      end
      4'b0101: begin
        push(0, 0, 0, 0, 0, "R3");
        v = mregs[b] & (ins[5] ? s5 : mregs[ins[2:0]]);
        wr(dr, v);
      end
      4'b1001: begin
        push(0, 0, 0, 0, 0, "R4");
        wr(dr, ~mregs[b]);
      end
      4'b1110: begin
        push(0, 0, 0, 0, 0, "R6");
        wr(dr, mpc + s9);
      end
      4'b0000: begin
        push(0, 0, 0, 0, 0, "R5,R9");
        if ((ins[11:9] & mcc) != 3'b000) mpc = mpc + s9;
      end
      4'b1100: begin
        push(0, 0, 0, 0, 0, "R10");
        mpc = mregs[b];
      end
      4'b0010, 4'b0110: begin
        ea = (ins[15:12] == 4'b0010) ? mpc + s9 : mregs[b] + s6;
        push(0, 0, 0, 0, 0, "R6");
        push(1, 0, ea, 0, 0, "R6,R12");
        push(0, 0, 0, 0, 0, "R6");
        wr(dr, mmem[ea[11:0]]);
      end
      4'b1010: begin
        ea = mpc + s9;
        push(0, 0, 0, 0, 0, "R8");
        push(1, 0, ea, 0, 0, "R8");
        push(0, 0, 0, 0, 0, "R8");
        ptr = mmem[ea[11:0]];
        push(1, 0, ptr, 0, 0, "R8");
        push(0, 0, 0, 0, 0, "R8");
        wr(dr, mmem[ptr[11:0]]);
      end
      4'b0011, 4'b0111: begin
        ea = (ins[15:12] == 4'b0011) ? mpc + s9 : mregs[b] + s6;
        push(0, 0, 0, 0, 0, "R7");
        push(1, 1, ea, mregs[dr], 0, "R7,R12");
        mmem[ea[11:0]] = mregs[dr];
      end
      4'b1011: begin
        ea = mpc + s9;
        push(0, 0, 0, 0, 0, "R8");
        push(1, 0, ea, 0, 0, "R8");
        push(0, 0, 0, 0, 0, "R8");
        ptr = mmem[ea[11:0]];
        push(1, 1, ptr, mregs[dr], 0, "R8");
        mmem[ptr[11:0]] = mregs[dr];
      end
      default: begin
        push(0, 0, 0, 0, 0, "R11");
        mhalted = 1;
      end
    endcase
  endtask

  // Program assembly helpers
  logic [15:0] pa;

  function automatic logic [15:0] A(int n);
    return 16'h3000 + 16'(n);
  endfunction

  function automatic logic [8:0] off9(logic [15:0] target);
    logic [15:0] d;
    d = target - (pa + 16'h1);
    return d[8:0];
  endfunction

  task automatic put(logic [15:0] w);
    mmem[pa[11:0]] = w;
    pa = pa + 16'h1;
  endtask

  task automatic opReg(logic [3:0] op, logic [2:0] dr, logic [2:0] s1, logic [2:0] s2);
    put({op, dr, s1, 3'b000, s2});
  endtask

  task automatic opImm(logic [3:0] op, logic [2:0] dr, logic [2:0] s1, logic [4:0] imm);
    put({op, dr, s1, 1'b1, imm});
  endtask

  task automatic opPc(logic [3:0] op, logic [2:0] dr, logic [15:0] target);
    put({op, dr, off9(target)});
  endtask

  task automatic opBase(logic [3:0] op, logic [2:0] dr, logic [2:0] base, logic [5:0] off);
    put({op, dr, base, off});
  endtask

  task automatic buildProgram();
    for (int i = 0; i < 4096; i++) mmem[i] = 16'h0;
    mmem[12'h060] = 16'h0005;
    mmem[12'h061] = 16'h8001;
    mmem[12'h062] = 16'h1234;
    mmem[12'h070] = 16'h3062;
    mmem[12'h071] = 16'h3080;
    pa = 16'h3000;
    opPc(4'b0000, 3'b111, A(2));          // 0  BR nzp, not taken after reset (R1)
    opImm(4'b0001, 3'd1, 3'd0, 5'h1F);    // 1  R1 = R0 + -1
    opPc(4'b0000, 3'b100, A(4));          // 2  BRn taken
    opImm(4'b0001, 3'd7, 3'd7, 5'd1);     // 3  skipped
    opPc(4'b1110, 3'd2, 16'h3060);        // 4  LEA R2
    opBase(4'b0110, 3'd3, 3'd2, 6'd1);    // 5  LDR R3
    opPc(4'b0010, 3'd4, 16'h3060);        // 6  LD R4
    opReg(4'b0001, 3'd5, 3'd3, 3'd4);     // 7  ADD R5 = R3 + R4
    opReg(4'b0101, 3'd6, 3'd1, 3'd5);     // 8  AND R6 = R1 & R5
    put({4'b1001, 3'd1, 3'd1, 6'h3F});    // 9  NOT R1 (same reg)
    opPc(4'b0000, 3'b010, A(12));         // 10 BRz taken
    opImm(4'b0001, 3'd7, 3'd7, 5'd5);     // 11 skipped
    opPc(4'b0000, 3'b001, A(14));         // 12 BRp not taken
    opImm(4'b0001, 3'd7, 3'd7, 5'd3);     // 13 R7 += 3
    opPc(4'b1010, 3'd0, 16'h3070);        // 14 LDI R0
    opReg(4'b0001, 3'd0, 3'd0, 3'd0);     // 15 R0 = R0 + R0
    opPc(4'b1011, 3'd0, 16'h3071);        // 16 STI R0
    opBase(4'b0111, 3'd5, 3'd2, 6'd3);    // 17 STR R5
    opBase(4'b0110, 3'd3, 3'd2, 6'd3);    // 18 LDR R3 reads back
    opImm(4'b0101, 3'd4, 3'd4, 5'd0);     // 19 R4 = 0
    opImm(4'b0001, 3'd4, 3'd4, 5'd3);     // 20 R4 = 3
    opReg(4'b0001, 3'd7, 3'd7, 3'd4);     // 21 loop: R7 += R4
    opImm(4'b0001, 3'd4, 3'd4, 5'h1F);    // 22 R4 -= 1
    opPc(4'b0000, 3'b001, A(21));         // 23 BRp loop
    opPc(4'b1110, 3'd1, A(27));           // 24 LEA R1
    put({4'b1100, 3'b000, 3'd1, 6'b0});   // 25 JMP R1
    opImm(4'b0001, 3'd7, 3'd7, 5'd15);    // 26 skipped
    opImm(4'b0101, 3'd6, 3'd6, 5'h10);    // 27 R6 &= -16
    for (int k = 0; k < 8; k++)
      opPc(4'b0011, 3'(k), 16'h3040 + 16'(k)); // 28..35 ST Rk
    put(16'hD000);                        // 36 unsupported opcode
  endtask

  initial begin
    int haltSeen = 0;
    itemT  it;
    string tg;
    for (int i = 0; i < 8; i++) mregs[i] = 16'h0;
    mpc = 16'h3000;
    mcc = 3'b000;
    mhalted = 0;
    buildProgram();
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(memAddr == 16'h3000, "R1", "reset memAddr", memAddr, 16'h3000);
    check(memWe == 1'b0, "R1", "reset memWe", {15'h0, memWe}, 16'h0);
    check(halted == 1'b0, "R1", "reset halted", {15'h0, halted}, 16'h0);
    @(posedge clk);
    #1 rstN = 1'b1;
    while (haltSeen < 6 && !finished) begin
      @(negedge clk);
      if (q.size() == 0) genStep();
      it = q.pop_front();
      tg = tq.pop_front();
      check(halted == it.halt, tg, "halted", {15'h0, halted}, {15'h0, it.halt});
      check(memWe == it.we, tg, "memWe", {15'h0, memWe}, {15'h0, it.we});
      if (it.chk) check(memAddr == it.addr, tg, "memAddr", memAddr, it.addr);
      if (it.we)  check(memWdata == it.wdata, tg, "memWdata", memWdata, it.wdata);
      if (it.halt) haltSeen++;
    end
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual hung expected halt");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule